// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a synchronous model of the command front end of a parallel flash part. It observes byte-write cycles (an address, a data byte and a one-cycle write strobe) and recognizes multi-write unlock sequences that all begin with the same two-write prefix. Depending on the third write, a sequence arms a single sector program operation, enters or leaves product identification mode, or continues into a longer boot-block lockout sequence. The lockout sequence ends with a seventh write that selects the lower or the upper boot block.

While identification mode is active, the block drives a read-override path. Reads of fixed addresses return the manufacturer code, the device code and the lock status of each boot block. The block also reports whether the current write address lies in a locked boot block, and whether a whole-chip erase may proceed. The memory array, the sector load buffer and the program timer are outside the block. The timer reports the end of a program cycle through `prog_done`.

The decoder is a seven-state machine:
- `S_IDLE`: waiting for a first write.
- `S_AA`: first write seen.
- `S_55`: prefix complete.
- `S_EXT_AA`, `S_EXT_55`, `S_EXT_40`: the second half of the lockout sequence.
- `S_LSEL`: waiting for the block-select write.

Its transitions are as follows:
- Each matching write advances the machine one state.
- A write of A0, 90 or F0 in `S_55` returns it to `S_IDLE` and issues a pulse (arm, identify-on or identify-off).
- A write of 80 in `S_55` moves it to `S_EXT_AA`.
- A valid select write in `S_LSEL` issues a lock pulse and returns to `S_IDLE`.
- Any mismatching write restarts the machine. It goes to `S_AA` when that write is itself AA@5555, and to `S_IDLE` otherwise.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Command matching compares only `wr_addr[14:0]` against the command addresses 5555 and 2AAA, plus all 8 data bits. Address bits 17..15 are ignored during matching.
- R2: The writes AA@5555, 55@2AAA, A0@5555 set `prog_armed` at the clock edge of the third write. A lone A0@5555 does not set it.
- R3: `prog_done` clears `prog_armed`. While `prog_armed` is high, writes are data loads: they neither advance the decoder nor change any mode.
- R4: The prefix followed by 90@5555 sets `id_mode`. The prefix followed by F0@5555 clears it.
- R5: With `id_mode` high, `rd_addr` 00000 gives `rd_ovr_data` 1F and `rd_addr` 00001 gives BA, in both cases with `rd_ovr_valid` high. `rd_ovr_valid` is low for every other address, except the two status addresses, and is always low outside identification mode.
- R6: With `id_mode` high, `rd_addr` 00002 reports the lower block and 3FFF2 reports the upper block. In both cases `rd_ovr_valid` is high and the data is FE when unlocked or FF when locked.
- R7: The lockout sequence is the prefix, then 80@5555, AA@5555, 55@2AAA and 40@5555. A following 00@00000 (full address) sets `lock_lo`. A following FF@3FFFF sets `lock_hi`.
- R8: A write that does not match the expected step aborts the sequence. That write then counts as a first step, so AA@5555 restarts at step two.
- R9: `wr_blocked` is high when `wr_addr` lies in a locked block. The lower block is 00000–01FFF and the upper block is 3E000–3FFFF. `chip_erase_ok` is low while either lock is set.
- R10: `rst_n` clears `id_mode`, `prog_armed` and the sequence state but leaves the locks unchanged. Only `fact_rst_n` clears `lock_lo` and `lock_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, models power-down |
| fact_rst_n | input | 1 | Asynchronous active-low factory clear of the lock flags |
| wr_en | input | 1 | One-cycle byte-write strobe |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| prog_done | input | 1 | End of the external program cycle |
| rd_addr | input | 18 | Read address |
| prog_armed | output | 1 | Writes enabled for one sector program |
| id_mode | output | 1 | Product identification mode active |
| lock_lo | output | 1 | Lower boot block locked |
| lock_hi | output | 1 | Upper boot block locked |
| chip_erase_ok | output | 1 | No boot block locked |
| wr_blocked | output | 1 | `wr_addr` falls in a locked boot block |
| rd_ovr_valid | output | 1 | Read-override data replaces array data |
| rd_ovr_data | output | 8 | Read-override data |

## Verification
The embedded properties check, on every cycle, a set of invariants:
- `prog_armed` and `id_mode` rise only after the matching final command byte.
- The locks never drop without a factory clear.
- The decoder stays idle while armed.
- `rd_ovr_valid` never rises outside identification mode.
- `wr_blocked` never rises without a lock.

Only the directed scenarios can show the remaining behaviour:
- the full multi-write orderings;
- the abort-and-restart on a repeated AA;
- address aliasing above bit 14;
- the wrong seventh write;
- the exact identification and status bytes;
- the boundaries of each boot block.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_AA,
        S_55,
        S_EXT_AA,
        S_EXT_55,
        S_EXT_40,
        S_LSEL
    } seq_e;

    localparam int unsigned CMD_AW  = 15;
    localparam logic [CMD_AW-1:0] CMD_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] CMD_ADDR_B = 15'h2AAA;

    localparam logic [7:0] D_UNLOCK1 = 8'hAA;
    localparam logic [7:0] D_UNLOCK2 = 8'h55;
    localparam logic [7:0] D_ARM     = 8'hA0;
    localparam logic [7:0] D_ID_ON   = 8'h90;
    localparam logic [7:0] D_ID_OFF  = 8'hF0;
    localparam logic [7:0] D_EXT     = 8'h80;
    localparam logic [7:0] D_LOCK    = 8'h40;
    localparam logic [7:0] D_SEL_LO  = 8'h00;
    localparam logic [7:0] D_SEL_HI  = 8'hFF;
endpackage

// File: rtl/fcmd_seq_fsm.sv
module fcmd_seq_fsm
    import fcmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              armed,
    output logic              arm_p,
    output logic              id_on_p,
    output logic              id_off_p,
    output logic              lock_lo_p,
    output logic              lock_hi_p
);
    seq_e st, nxt;

    logic [CMD_AW-1:0] cmd_a;
    logic at_a, at_b, first_ok, step2_ok, wr_live;
    logic sel_lo, sel_hi;
    seq_e restart;

    assign cmd_a    = wr_addr[CMD_AW-1:0];
    assign at_a     = (cmd_a == CMD_ADDR_A);
    assign at_b     = (cmd_a == CMD_ADDR_B);
    assign first_ok = at_a && (wr_data == D_UNLOCK1);
    assign step2_ok = at_b && (wr_data == D_UNLOCK2);
    assign wr_live  = wr_en && !armed;
    assign sel_lo   = (wr_addr == '0) && (wr_data == D_SEL_LO);
    assign sel_hi   = (wr_addr == {ADDR_W{1'b1}}) && (wr_data == D_SEL_HI);
    assign restart  = first_ok ? S_AA : S_IDLE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt       = st;
        arm_p     = 1'b0;
        id_on_p   = 1'b0;
        id_off_p  = 1'b0;
        lock_lo_p = 1'b0;
        lock_hi_p = 1'b0;
        if (wr_live) begin
            unique case (st)
                S_IDLE:   nxt = restart;
                S_AA:     nxt = step2_ok ? S_55 : restart;
                S_55: begin
                    nxt = restart;
                    if (at_a) begin
                        unique case (wr_data)
                            D_ARM:    begin arm_p    = 1'b1; nxt = S_IDLE; end
                            D_ID_ON:  begin id_on_p  = 1'b1; nxt = S_IDLE; end
                            D_ID_OFF: begin id_off_p = 1'b1; nxt = S_IDLE; end
                            D_EXT:    nxt = S_EXT_AA;
                            default:  nxt = restart;
                        endcase
                    end
                end
                S_EXT_AA: nxt = first_ok ? S_EXT_55 : restart;
                S_EXT_55: nxt = step2_ok ? S_EXT_40 : restart;
                S_EXT_40: nxt = (at_a && wr_data == D_LOCK) ? S_LSEL : restart;
                S_LSEL: begin
                    if (sel_lo) begin
                        lock_lo_p = 1'b1;
                        nxt = S_IDLE;
                    end else if (sel_hi) begin
                        lock_hi_p = 1'b1;
                        nxt = S_IDLE;
                    end else begin
                        nxt = restart;
                    end
                end
                default:  nxt = S_IDLE;
            endcase
        end
    end

    // R3
    idle_while_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> st == S_IDLE);

    // R7
    lock_pulse_from_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lo_p || lock_hi_p) |-> st == S_LSEL);
endmodule

// File: rtl/fcmd_mode_regs.sv
module fcmd_mode_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic fact_rst_n,
    input  logic arm_p,
    input  logic id_on_p,
    input  logic id_off_p,
    input  logic lock_lo_p,
    input  logic lock_hi_p,
    input  logic prog_done,
    output logic prog_armed,
    output logic id_mode,
    output logic lock_lo,
    output logic lock_hi
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_armed <= 1'b0;
            id_mode    <= 1'b0;
        end else begin
            if (arm_p)          prog_armed <= 1'b1;
            else if (prog_done) prog_armed <= 1'b0;
            if (id_on_p)        id_mode <= 1'b1;
            else if (id_off_p)  id_mode <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge fact_rst_n) begin
        if (!fact_rst_n) begin
            lock_lo <= 1'b0;
            lock_hi <= 1'b0;
        end else begin
            if (lock_lo_p) lock_lo <= 1'b1;
            if (lock_hi_p) lock_hi <= 1'b1;
        end
    end

    // R10
    lock_lo_sticky_chk: assert property (@(posedge clk) disable iff (!fact_rst_n)
        lock_lo |=> lock_lo);

    // R10
    lock_hi_sticky_chk: assert property (@(posedge clk) disable iff (!fact_rst_n)
        lock_hi |=> lock_hi);
endmodule

// File: rtl/fcmd_id_view.sv
module fcmd_id_view #(
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned BOOT_LOG = 13,
    parameter logic [7:0]  MFR_ID   = 8'h1F,
    parameter logic [7:0]  DEV_ID   = 8'hBA
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              id_mode,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output logic              rd_ovr_valid,
    output logic [7:0]        rd_ovr_data,
    output logic              wr_blocked,
    output logic              chip_erase_ok
);
    localparam int unsigned HI_W = ADDR_W - BOOT_LOG;
    localparam logic [ADDR_W-1:0] A_MFR     = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DEV     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_LO_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_HI_STAT = {ADDR_W{1'b1}} - ADDR_W'(13);

    logic in_lo, in_hi;

    assign in_lo = (wr_addr[ADDR_W-1:BOOT_LOG] == {HI_W{1'b0}});
    assign in_hi = (wr_addr[ADDR_W-1:BOOT_LOG] == {HI_W{1'b1}});
    assign wr_blocked    = (in_lo && lock_lo) || (in_hi && lock_hi);
    assign chip_erase_ok = !(lock_lo || lock_hi);

    always_comb begin
        rd_ovr_valid = 1'b0;
        rd_ovr_data  = 8'hFF;
        if (id_mode) begin
            rd_ovr_valid = 1'b1;
            unique case (rd_addr)
                A_MFR:     rd_ovr_data = MFR_ID;
                A_DEV:     rd_ovr_data = DEV_ID;
                A_LO_STAT: rd_ovr_data = {7'h7F, lock_lo};
                A_HI_STAT: rd_ovr_data = {7'h7F, lock_hi};
                default:   rd_ovr_valid = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcmd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned BOOT_LOG = 13,
    parameter logic [7:0]  MFR_ID   = 8'h1F,
    parameter logic [7:0]  DEV_ID   = 8'hBA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fact_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prog_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_armed,
    output logic              id_mode,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic              chip_erase_ok,
    output logic              wr_blocked,
    output logic              rd_ovr_valid,
    output logic [7:0]        rd_ovr_data
);
    logic arm_p, id_on_p, id_off_p, lock_lo_p, lock_hi_p;

    fcmd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .armed(prog_armed), .arm_p(arm_p),
        .id_on_p(id_on_p), .id_off_p(id_off_p),
        .lock_lo_p(lock_lo_p), .lock_hi_p(lock_hi_p)
    );

    fcmd_mode_regs u_regs (
        .clk(clk), .rst_n(rst_n), .fact_rst_n(fact_rst_n),
        .arm_p(arm_p), .id_on_p(id_on_p), .id_off_p(id_off_p),
        .lock_lo_p(lock_lo_p), .lock_hi_p(lock_hi_p), .prog_done(prog_done),
        .prog_armed(prog_armed), .id_mode(id_mode),
        .lock_lo(lock_lo), .lock_hi(lock_hi)
    );

    fcmd_id_view #(
        .ADDR_W(ADDR_W), .BOOT_LOG(BOOT_LOG), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) u_view (
        .rd_addr(rd_addr), .wr_addr(wr_addr), .id_mode(id_mode),
        .lock_lo(lock_lo), .lock_hi(lock_hi),
        .rd_ovr_valid(rd_ovr_valid), .rd_ovr_data(rd_ovr_data),
        .wr_blocked(wr_blocked), .chip_erase_ok(chip_erase_ok)
    );

    // R2
    arm_after_a0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_armed) |-> $past(wr_en && wr_data == D_ARM
                                    && wr_addr[CMD_AW-1:0] == CMD_ADDR_A));

    // R4
    id_after_90_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> $past(wr_en && wr_data == D_ID_ON
                                 && wr_addr[CMD_AW-1:0] == CMD_ADDR_A));

    // R5
    ovr_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ovr_valid |-> id_mode);

    // R9
    blocked_needs_lock_chk: assert property (@(posedge clk) disable iff (!fact_rst_n)
        wr_blocked |-> (lock_lo || lock_hi));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fact_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_done = 1'b0;
    logic [17:0] rd_addr = '0;
    logic        prog_armed, id_mode, lock_lo, lock_hi;
    logic        chip_erase_ok, wr_blocked, rd_ovr_valid;
    logic [7:0]  rd_ovr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .fact_rst_n(fact_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_done(prog_done), .rd_addr(rd_addr),
        .prog_armed(prog_armed), .id_mode(id_mode),
        .lock_lo(lock_lo), .lock_hi(lock_hi),
        .chip_erase_ok(chip_erase_ok), .wr_blocked(wr_blocked),
        .rd_ovr_valid(rd_ovr_valid), .rd_ovr_data(rd_ovr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock3(input logic [7:0] cmd);
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(18'h05555, cmd);
    endtask

    task automatic lock_prefix();
        unlock3(8'h80);
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(18'h05555, 8'h40);
    endtask

    task automatic finish_prog();
        @(negedge clk); prog_done = 1'b1;
        @(negedge clk); prog_done = 1'b0;
    endtask

    task automatic rd(input logic [17:0] a);
        rd_addr = a;
        #1;
    endtask

    task automatic t_reset();
        chk("R10 armed after reset", prog_armed, 0);
        chk("R10 id after reset", id_mode, 0);
        chk("R10 locks after factory clear", {lock_hi, lock_lo}, 0);
        chk("R9 erase ok unlocked", chip_erase_ok, 1);
        rd(18'h0);
        chk("R5 no override outside id", rd_ovr_valid, 0);
    endtask

    task automatic t_arm();
        wr(18'h05555, 8'hA0);
        chk("R2 lone A0 no arm", prog_armed, 0);
        unlock3(8'hA0);
        chk("R2 armed", prog_armed, 1);
        unlock3(8'h90);
        chk("R3 writes ignored while armed", id_mode, 0);
        chk("R3 still armed", prog_armed, 1);
        finish_prog();
        chk("R3 done clears arm", prog_armed, 0);
    endtask

    task automatic t_alias();
        wr(18'h0D555, 8'hAA);
        wr(18'h1AAAA, 8'h55);
        wr(18'h3D555, 8'hA0);
        chk("R1 upper addr bits ignored", prog_armed, 1);
        finish_prog();
        wr(18'h05555, 8'hAA);
        wr(18'h02AAB, 8'h55);
        wr(18'h05555, 8'hA0);
        chk("R1 low bit mismatch", prog_armed, 0);
    endtask

    task automatic t_abort();
        wr(18'h05555, 8'hAA);
        unlock3(8'hA0);
        chk("R8 repeated AA restarts", prog_armed, 1);
        finish_prog();
        unlock3(8'h33);
        wr(18'h05555, 8'hA0);
        chk("R8 bad cmd aborts", prog_armed, 0);
    endtask

    task automatic t_id();
        unlock3(8'h90);
        chk("R4 id on", id_mode, 1);
        rd(18'h00000);
        chk("R5 mfr valid", rd_ovr_valid, 1);
        chk("R5 mfr code", rd_ovr_data, 8'h1F);
        rd(18'h00001);
        chk("R5 dev code", rd_ovr_data, 8'hBA);
        rd(18'h00005);
        chk("R5 other addr no override", rd_ovr_valid, 0);
        rd(18'h00002);
        chk("R6 lo status unlocked", rd_ovr_data, 8'hFE);
        rd(18'h3FFF2);
        chk("R6 hi status valid", rd_ovr_valid, 1);
        chk("R6 hi status unlocked", rd_ovr_data, 8'hFE);
        unlock3(8'hF0);
        chk("R4 id off", id_mode, 0);
        rd(18'h00000);
        chk("R5 off no override", rd_ovr_valid, 0);
    endtask

    task automatic t_lock_lo();
        lock_prefix();
        wr(18'h00000, 8'h00);
        chk("R7 lock lo", {lock_hi, lock_lo}, 2'b01);
        chk("R9 erase blocked", chip_erase_ok, 0);
        @(negedge clk); wr_addr = 18'h01FFF; #1;
        chk("R9 lo top blocked", wr_blocked, 1);
        wr_addr = 18'h02000; #1;
        chk("R9 above lo free", wr_blocked, 0);
        unlock3(8'h90);
        rd(18'h00002);
        chk("R6 lo status locked", rd_ovr_data, 8'hFF);
        rd(18'h3FFF2);
        chk("R6 hi status still free", rd_ovr_data, 8'hFE);
        unlock3(8'hF0);
    endtask

    task automatic t_lock_hi();
        lock_prefix();
        wr(18'h3FFFF, 8'h00);
        chk("R8 wrong select no lock", lock_hi, 0);
        lock_prefix();
        wr(18'h3FFFF, 8'hFF);
        chk("R7 lock hi", lock_hi, 1);
        @(negedge clk); wr_addr = 18'h3E000; #1;
        chk("R9 hi bottom blocked", wr_blocked, 1);
        wr_addr = 18'h3DFFF; #1;
        chk("R9 below hi free", wr_blocked, 0);
    endtask

    task automatic t_resets();
        unlock3(8'h90);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 reset clears id", id_mode, 0);
        chk("R10 locks survive reset", {lock_hi, lock_lo}, 2'b11);
        @(negedge clk); fact_rst_n = 1'b0;
        @(negedge clk); fact_rst_n = 1'b1;
        chk("R10 factory clears locks", {lock_hi, lock_lo}, 2'b00);
        chk("R9 erase ok again", chip_erase_ok, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; fact_rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arm();
        t_alias();
        t_abort();
        t_id();
        t_lock_lo();
        t_lock_hi();
        t_resets();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule